// File: doc/BRIEF.md
# Paged Address Translator with Page Protection

This block widens the 16-bit address space of an 8-bit processor to a 20-bit physical space. The top four address bits pick one of sixteen page entries, and each entry covers 4 KB. An entry holds an 8-bit frame number, which becomes physical bits 19..12, and three attribute bits that guard the page. The processor sets up the entries by writing into a window of the I/O area. While attribute checks are active, a violating access does not go through. Instead the block drops the memory-select qualifier, so memory stays untouched, and it latches a bus-error flag that an auxiliary master can inspect.

After reset the block runs in pass-through mode and all attribute checks are off. The first write to any page entry switches it to mapped mode, and it stays there until the next reset. The attribute bits do not come from the data bus. A separate 3-bit attribute latch in the I/O area supplies them, and they are copied into an entry together with its frame number whenever software writes that entry. The block also keeps a copy of the last address presented outside the I/O area. An external master can read that copy, one byte at a time, through the I/O window.

Top module: `paged_mmu`

## Requirements
- R1: In mapped mode, `phys_addr` equals {frame of entry `cpu_addr[15:12]`, `cpu_addr[11:0]`}, combinationally.
- R2: In pass-through mode, `phys_addr` equals {4'b0, `cpu_addr`}. In this mode `viol` is 0 and `mem_sel` equals the inverse of `io_sel`.
- R3: Reset selects pass-through mode. A write with `io_sel`=1, `cpu_rnw`=0 and `cpu_addr[11:4]`=8'hFF is a page-entry write, and it selects mapped mode from the next cycle until the next reset.
- R4: A page-entry write stores `cpu_wdata` as the frame of entry `cpu_addr[3:0]`. It also copies the attribute latch into that entry. The latch is written with `cpu_wdata[2:0]` by a write with `cpu_addr[11:4]`=8'hFD and `cpu_addr[1]`=0. Latch and entry bit 0 is write-protect, bit 1 is not-mapped, and bit 2 is no-execute.
- R5: In mapped mode, a write (`cpu_rnw`=0, `io_sel`=0) to a write-protected page sets `viol[0]` and forces `mem_sel` low. Reads from that page are unaffected.
- R6: In mapped mode, any access with `io_sel`=0 to a not-mapped page sets `viol[1]` and forces `mem_sel` low.
- R7: In mapped mode, an access with `cpu_sync`=1 and `io_sel`=0 to a no-execute page sets `viol[2]` and forces `mem_sel` low. Accesses with `cpu_sync`=0 are unaffected.
- R8: Reset clears the attribute latch and every entry to zero. Right after mapped mode is entered, pages that have not been written translate to frame 0 and raise no violation.
- R9: `bus_err` goes high in the cycle after any cycle with a nonzero `viol`. It then stays high until a reset or an attribute-latch write.
- R10: A read with `io_sel`=1, `cpu_addr[11:4]`=8'hFD and `cpu_addr[1]`=1 returns the captured address on `io_rdata`, the high byte when `cpu_addr[0]`=1 and the low byte otherwise. `cpu_addr[3:2]` is ignored (mirrors). The captured address is the `cpu_addr` of the latest cycle with `io_sel`=0, and it is 0 after reset.
- R11: `mem_sel` is low whenever `io_sel` is high, and `io_rdata` is 0 in every cycle that is not an R10 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_sync | input | 1 | High during an opcode fetch |
| io_sel | input | 1 | Access falls in the I/O area |
| phys_addr | output | 20 | Translated physical address |
| mem_sel | output | 1 | Memory-select qualifier, high = memory may respond |
| viol | output | 3 | Current violation: bit0 write-protect, bit1 not-mapped, bit2 no-execute |
| bus_err | output | 1 | Sticky registered bus-error flag |
| io_rdata | output | 8 | Captured-address readback byte |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 4-bit page index and therefore sixteen entries, and 8-bit frames. With these values a random run can hit every page entry, all eight attribute combinations and every mirror of the readback and latch offsets in a few thousand cycles. Directed sequences cover the pass-through window before the first entry write, each attribute kind on its own, clearing the error flag, the mirrored readback, and a second reset that falls back to pass-through.

// File: rtl/paged_mmu_pkg.sv
package paged_mmu_pkg;

    localparam int FRAME_W  = 8;
    localparam int IO_OFF_W = 12;

    // bit 2 = no-execute, bit 1 = not-mapped, bit 0 = write-protect
    typedef struct packed {
        logic nx;
        logic nm;
        logic wp;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    typedef struct packed {
        attr_t              attr;
        logic [FRAME_W-1:0] frame;
    } page_ent_t;

    typedef enum logic [1:0] {
        IO_NONE,
        IO_CTRL,
        IO_PAGE,
        IO_RDBK
    } io_tgt_e;

    // Partial decode of the I/O-area offset.
    function automatic io_tgt_e io_decode(input logic [IO_OFF_W-1:0] off);
        io_tgt_e t;
        t = IO_NONE;
        if (off[11:4] == 8'hFF)
            t = IO_PAGE;
        else if (off[11:4] == 8'hFD)
            t = off[1] ? IO_RDBK : IO_CTRL;
        return t;
    endfunction

endpackage

// File: rtl/paged_mmu_regfile.sv
module paged_mmu_regfile
    import paged_mmu_pkg::*;
#(
    parameter int PAGE_IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_page,
    input  logic                  wr_ctrl,
    input  logic [PAGE_IDX_W-1:0] wr_idx,
    input  logic [FRAME_W-1:0]    wdata,
    input  logic [PAGE_IDX_W-1:0] rd_idx,
    output page_ent_t             rd_ent,
    output logic                  map_mode
);

    localparam int PAGE_CNT = 1 << PAGE_IDX_W;

    page_ent_t              ent_q [PAGE_CNT];
    attr_t                  latch_q;
    logic                   mode_q;
    logic [PAGE_CNT-1:0]    ent_we;

    for (genvar g = 0; g < PAGE_CNT; g++) begin : g_we
        assign ent_we[g] = wr_page && (wr_idx == PAGE_IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAGE_CNT; i++)
                ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < PAGE_CNT; i++)
                if (ent_we[i])
                    ent_q[i] <= '{attr: latch_q, frame: wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '0;
        else if (wr_ctrl)
            latch_q <= attr_t'(wdata[ATTR_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= 1'b0;
        else if (wr_page)
            mode_q <= 1'b1;
    end

    assign rd_ent   = ent_q[rd_idx];
    assign map_mode = mode_q;

    AST_MODE_SET_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_page |=> map_mode);                               // R3
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        map_mode |=> map_mode);                              // R3

endmodule

// File: rtl/paged_mmu_xlate.sv
module paged_mmu_xlate
    import paged_mmu_pkg::*;
#(
    parameter int VA_W       = 16,
    parameter int PAGE_IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            map_mode,
    input  page_ent_t       ent,
    input  logic [VA_W-1:0] cpu_addr,
    input  logic            cpu_rnw,
    input  logic            cpu_sync,
    input  logic            io_sel,
    output logic [VA_W-PAGE_IDX_W+FRAME_W-1:0] phys_addr,
    output attr_t           viol,
    output logic            mem_sel
);

    localparam int OFF_W = VA_W - PAGE_IDX_W;
    localparam int PA_W  = OFF_W + FRAME_W;
    localparam int PAD_W = PA_W - VA_W;

    logic checks_on;

    assign checks_on = map_mode && !io_sel;

    always_comb begin
        if (map_mode)
            phys_addr = {ent.frame, cpu_addr[OFF_W-1:0]};
        else
            phys_addr = {{PAD_W{1'b0}}, cpu_addr};
    end

    always_comb begin
        viol.wp = checks_on && ent.attr.wp && !cpu_rnw;
        viol.nm = checks_on && ent.attr.nm;
        viol.nx = checks_on && ent.attr.nx && cpu_sync;
    end

    assign mem_sel = !io_sel && !(viol.wp || viol.nm || viol.nx);

    AST_PASS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !map_mode |-> (phys_addr[PA_W-1:VA_W] == '0));       // R2
    AST_PASS_NO_VIOL: assert property (@(posedge clk) disable iff (rst)
        !map_mode |-> (viol == '0));                         // R2
    AST_IO_NO_MEMSEL: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> !mem_sel);                                // R11
    AST_WP_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (map_mode && !io_sel && ent.attr.wp && !cpu_rnw) |-> !mem_sel); // R5

endmodule

// File: rtl/paged_mmu_capture.sv
module paged_mmu_capture #(
    parameter int VA_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   cpu_addr,
    input  logic              io_sel,
    input  logic              rd_en,
    input  logic              hi_sel,
    output logic [DATA_W-1:0] rdata
);

    logic [VA_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (!io_sel)
            cap_q <= cpu_addr;
    end

    always_comb begin
        rdata = '0;
        if (rd_en)
            rdata = hi_sel ? cap_q[VA_W-1 -: DATA_W] : cap_q[DATA_W-1:0];
    end

    AST_CAPTURE_HELD_IN_IO: assert property (@(posedge clk) disable iff (rst)
        (io_sel && rd_en) |=> $stable(cap_q) || !$past(io_sel)); // R10

endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
    import paged_mmu_pkg::*;
#(
    parameter int VA_W       = 16,
    parameter int PAGE_IDX_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [VA_W-1:0]                       cpu_addr,
    input  logic [FRAME_W-1:0]                    cpu_wdata,
    input  logic                                  cpu_rnw,
    input  logic                                  cpu_sync,
    input  logic                                  io_sel,
    output logic [VA_W-PAGE_IDX_W+FRAME_W-1:0]    phys_addr,
    output logic                                  mem_sel,
    output logic [ATTR_W-1:0]                     viol,
    output logic                                  bus_err,
    output logic [FRAME_W-1:0]                    io_rdata
);

    io_tgt_e   io_tgt;
    logic      wr_page;
    logic      wr_ctrl;
    logic      rd_rdbk;
    logic      map_mode;
    page_ent_t cur_ent;
    attr_t     viol_s;
    logic      err_q;

    assign io_tgt  = io_decode(cpu_addr[IO_OFF_W-1:0]);
    assign wr_page = io_sel && !cpu_rnw && (io_tgt == IO_PAGE);
    assign wr_ctrl = io_sel && !cpu_rnw && (io_tgt == IO_CTRL);
    assign rd_rdbk = io_sel &&  cpu_rnw && (io_tgt == IO_RDBK);

    paged_mmu_regfile #(.PAGE_IDX_W(PAGE_IDX_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_page  (wr_page),
        .wr_ctrl  (wr_ctrl),
        .wr_idx   (cpu_addr[PAGE_IDX_W-1:0]),
        .wdata    (cpu_wdata),
        .rd_idx   (cpu_addr[VA_W-1 -: PAGE_IDX_W]),
        .rd_ent   (cur_ent),
        .map_mode (map_mode)
    );

    paged_mmu_xlate #(.VA_W(VA_W), .PAGE_IDX_W(PAGE_IDX_W)) xlate_i (
        .clk       (clk),
        .rst       (rst),
        .map_mode  (map_mode),
        .ent       (cur_ent),
        .cpu_addr  (cpu_addr),
        .cpu_rnw   (cpu_rnw),
        .cpu_sync  (cpu_sync),
        .io_sel    (io_sel),
        .phys_addr (phys_addr),
        .viol      (viol_s),
        .mem_sel   (mem_sel)
    );

    paged_mmu_capture #(.VA_W(VA_W), .DATA_W(FRAME_W)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .io_sel   (io_sel),
        .rd_en    (rd_rdbk),
        .hi_sel   (cpu_addr[0]),
        .rdata    (io_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (viol_s != '0)
            err_q <= 1'b1;
        else if (wr_ctrl)
            err_q <= 1'b0;
    end

    assign viol    = viol_s;
    assign bus_err = err_q;

    AST_ERR_RAISED: assert property (@(posedge clk) disable iff (rst)
        (viol != '0) |=> bus_err);                           // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !wr_ctrl) |=> bus_err);                  // R9
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> !bus_err);                               // R9
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(io_sel && cpu_rnw && cpu_addr[11:4] == 8'hFD && cpu_addr[1])
            |-> (io_rdata == '0));                           // R11

endmodule

// File: tb/paged_mmu_tb_top.sv
module paged_mmu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rnw = 1'b1;
    logic        cpu_sync = 1'b0;
    logic        io_sel = 1'b0;
    logic [19:0] phys_addr;
    logic        mem_sel;
    logic [2:0]  viol;
    logic        bus_err;
    logic [7:0]  io_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench-side model state
    logic [7:0]  m_frame [16];
    logic [2:0]  m_attr  [16];
    logic [2:0]  m_latch;
    logic        m_mode;
    logic        m_err;
    logic [15:0] m_cap;

    always #2 clk = ~clk;

    paged_mmu dut_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rnw   (cpu_rnw),
        .cpu_sync  (cpu_sync),
        .io_sel    (io_sel),
        .phys_addr (phys_addr),
        .mem_sel   (mem_sel),
        .viol      (viol),
        .bus_err   (bus_err),
        .io_rdata  (io_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (addr %h io %0b rnw %0b sync %0b)",
                     tag, act, exp, cpu_addr, io_sel, cpu_rnw, cpu_sync);
        end
    endtask

    function automatic logic [2:0] exp_viol(input logic [15:0] a, input logic rnw,
                                            input logic sync, input logic io);
        logic [2:0] at;
        at = m_attr[a[15:12]];
        if (!m_mode || io) return 3'b000;
        return {at[2] & sync, at[1], at[0] & ~rnw};
    endfunction

    function automatic logic [19:0] exp_phys(input logic [15:0] a);
        return m_mode ? {m_frame[a[15:12]], a[11:0]} : {4'h0, a};
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [15:0] a, input logic rnw, input logic io);
        if (io && rnw && a[11:4] == 8'hFD && a[1])
            return a[0] ? m_cap[15:8] : m_cap[7:0];
        return 8'h00;
    endfunction

    function automatic string viol_tag(input logic [15:0] a, input logic rnw,
                                       input logic sync, input logic io);
        logic [2:0] at;
        at = m_attr[a[15:12]];
        if (io) return "R11";
        if (!m_mode) return "R2";
        if (at[1]) return "R6";
        if (at[2] && sync) return "R7";
        if (at[0] && !rnw) return "R5";
        return "R4";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_frame[i] = 8'h00;
            m_attr[i]  = 3'b000;
        end
        m_latch = 3'b000;
        m_mode  = 1'b0;
        m_err   = 1'b0;
        m_cap   = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        io_sel = 1'b0; cpu_rnw = 1'b1; cpu_sync = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One bus cycle: drive after the falling edge, check, then advance the model.
    task automatic bus(input logic [15:0] a, input logic [7:0] wd, input logic rnw,
                       input logic sync, input logic io);
        logic [2:0] ev;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = wd; cpu_rnw = rnw; cpu_sync = sync; io_sel = io;
        #1;
        ev = exp_viol(a, rnw, sync, io);
        check(m_mode ? "R1" : "R2", 32'(phys_addr), 32'(exp_phys(a)));
        check(viol_tag(a, rnw, sync, io), 32'(viol), 32'(ev));
        check(viol_tag(a, rnw, sync, io), 32'(mem_sel), 32'(!io && ev == 3'b000));
        check((io && rnw && a[11:4] == 8'hFD && a[1]) ? "R10" : "R11",
              32'(io_rdata), 32'(exp_rdata(a, rnw, io)));
        check("R9", 32'(bus_err), 32'(m_err));
        @(posedge clk);
        if (io && !rnw && a[11:4] == 8'hFF) begin
            m_frame[a[3:0]] = wd;
            m_attr[a[3:0]]  = m_latch;
            m_mode          = 1'b1;
        end
        if (io && !rnw && a[11:4] == 8'hFD && !a[1])
            m_latch = wd[2:0];
        if (ev != 3'b000)
            m_err = 1'b1;
        else if (io && !rnw && a[11:4] == 8'hFD && !a[1])
            m_err = 1'b0;
        if (!io)
            m_cap = a;
    endtask

    task automatic wr_io(input logic [11:0] off, input logic [7:0] d);
        bus({4'hE, off}, d, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [15:0] a;
        logic [7:0]  d;
        logic        rnw, sync, io;
        seed = 32'd12345;
        void'($urandom(seed));
        model_reset();
        do_reset();

        // R8/R9/R11: reset state
        #1;
        check("R9",  32'(bus_err), 32'h0);
        check("R11", 32'(io_rdata), 32'h0);
        check("R2",  32'(phys_addr[19:16]), 32'h0);

        // R2: pass-through, latch loaded with all attributes but no checks yet
        bus(16'hC123, 8'h00, 1'b1, 1'b1, 1'b0);
        wr_io(12'hFD0, 8'h07);
        bus(16'h3456, 8'h00, 1'b0, 1'b1, 1'b0);
        bus(16'h3456, 8'h00, 1'b1, 1'b1, 1'b0);

        // R3/R4/R8: first entry write with a clear latch enters mapped mode
        wr_io(12'hFD0, 8'h00);
        wr_io(12'hFF3, 8'h5A);
        @(negedge clk); cpu_addr = 16'h3ABC; io_sel = 1'b0; cpu_rnw = 1'b1; cpu_sync = 1'b0; #1;
        check("R3", 32'(phys_addr), 32'h5AABC);
        check("R8", 32'(viol), 32'h0);
        bus(16'h9FFF, 8'h00, 1'b0, 1'b1, 1'b0);   // untouched page: frame 0, no violation (R8)

        // R5: write-protect page 5
        wr_io(12'hFD1, 8'h01);
        wr_io(12'hFF5, 8'h12);
        bus(16'h5123, 8'h00, 1'b1, 1'b0, 1'b0);   // read passes
        bus(16'h5123, 8'hAA, 1'b0, 1'b0, 1'b0);   // write blocked
        bus(16'h5124, 8'h00, 1'b1, 1'b0, 1'b0);   // R9 flag now high
        wr_io(12'hFD4, 8'h00);                    // mirror of latch clears flag (R9)
        bus(16'h0000, 8'h00, 1'b1, 1'b0, 1'b0);

        // R6: not-mapped page 6
        wr_io(12'hFD0, 8'h02);
        wr_io(12'hFF6, 8'h34);
        bus(16'h6000, 8'h00, 1'b1, 1'b0, 1'b0);
        // R7: no-execute page 7
        wr_io(12'hFD0, 8'h04);
        wr_io(12'hFF7, 8'h77);
        bus(16'h7010, 8'h00, 1'b1, 1'b0, 1'b0);   // data read fine
        bus(16'h7011, 8'h00, 1'b1, 1'b1, 1'b0);   // fetch faults
        wr_io(12'hFD0, 8'h00);

        // R10: readback with mirrors
        bus(16'hBEEF, 8'h00, 1'b1, 1'b0, 1'b0);
        bus(16'hEFD2, 8'h00, 1'b1, 1'b0, 1'b1);
        bus(16'hEFD3, 8'h00, 1'b1, 1'b0, 1'b1);
        bus(16'hEFDE, 8'h00, 1'b1, 1'b0, 1'b1);
        bus(16'hEFDF, 8'h00, 1'b1, 1'b0, 1'b1);
        bus(16'hEFDF, 8'h00, 1'b0, 1'b0, 1'b1);   // write: no readback (R11)

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            io   = ($urandom % 4) == 0;
            rnw  = ($urandom % 3) != 0;
            sync = ($urandom % 3) == 0;
            a    = 16'($urandom);
            d    = 8'($urandom);
            if (io) begin
                case ($urandom % 4)
                    0: a[11:4] = 8'hFD;
                    1: a[11:4] = 8'hFF;
                    2: begin a[11:4] = 8'hFD; d = ($urandom % 2) ? 8'h00 : d; end
                    default: ;
                endcase
            end
            bus(a, d, rnw, sync, io);
        end

        // R3: reset returns to pass-through
        do_reset();
        bus(16'h5123, 8'h00, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule